// File: doc/BRIEF.md
# Expansion Registers and Paged Work RAM

This block decodes the low half of a cartridge's CPU address space. The window from 0x5000 to 0x5FFF holds a small scratch RAM. Three addresses in that window also feed one-shot snapshot registers. The 8 KB window from 0x6000 to 0x7FFF reaches either a default work-RAM bank or one of four private work-RAM pages. A control byte from the main bank logic picks which one. One further register at 0x5FF3 can tell the program-bank logic to force every program slot to bank 0.

The snapshot registers work as a simple protection handshake. The first write after reset to 0x5000, 0x5010 or 0x5013 is copied into the matching snapshot register. Later writes to those addresses do not change the snapshot. The snapshot is then visible at 0x6000, 0x6010 or 0x6013 for one read only. After that read, the address shows the normal work-RAM contents again.

All reads are synchronous. A read strobe presented in one cycle returns data with `rd_valid` in the next cycle. The memory depths are parameters. A window larger than its memory aliases onto the low address bits.

Top module: `xreg_wram`

## Requirements
- R1: A write in 0x5000-0x5FFF stores into the scratch RAM at address bits [SCR_AW-1:0]. A read there returns that byte on `rd_data` with `rd_valid` high in the cycle after the read strobe.
- R2: The first write after reset to 0x5000, 0x5010 or 0x5013 copies its data into that address's snapshot. Later writes to the same address leave the snapshot unchanged, although they still reach the scratch RAM.
- R3: When no page is selected, the first read after reset of 0x6000, 0x6010 or 0x6013 returns the matching snapshot (0 if it was never written). Every later read of that address returns default-bank data.
- R4: A page is selected when control bits [7:5] are all 1, which is the same as `ctrl & 0xE3` being 0xE0 to 0xE3. Control bits [1:0] give the page number, and bits [4:2] are ignored. While a page is selected, reads and writes in 0x6000-0x7FFF use that page at address bits [PAGE_AW-1:0].
- R5: A write to page 0 also writes the same location in the default bank. Writes to pages 1 to 3 leave the default bank unchanged.
- R6: When no page is selected, reads and writes in 0x6000-0x7FFF use the default bank.
- R7: A page selection takes priority over a snapshot read. A read of a snapshot address while a page is selected returns page data and leaves that snapshot still readable once.
- R8: `prg_force_zero` is high exactly while the most recent value written to 0x5FF3 is 2.
- R9: Reset clears every snapshot and the 0x5FF3 register, re-arms all one-shot write and read flags, and drives `rd_valid` low.
- R10: A read outside 0x5000-0x7FFF gives `rd_valid` low and `rd_data` equal to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| ctrl_byte | input | 8 | Paging control byte from the bank logic |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| prg_force_zero | output | 1 | Request to force all program slots to bank 0 |

## Verification
The hardest case to reach is a snapshot read that is still armed while a page is selected. Each snapshot can be consumed only once per reset, so a single stray read of 0x6000 destroys that state. To reach it, the bench arms 0x5000 and selects page 0. It writes to 0x6000, then reads 0x6000 through the page. It then clears the selection and reads 0x6000 twice. The first of these reads must show the snapshot and the second must show the page-0 shadow value in the default bank. A later reset followed by a fresh write shows that the flags re-arm.

// File: rtl/xreg_wram.sv
module xreg_wram #(
  parameter int SCR_AW  = 8,
  parameter int PAGE_AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [7:0]  ctrl_byte,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        prg_force_zero
);
  localparam int SCR_DEPTH  = 1 << SCR_AW;
  localparam int NPAGES     = 4;
  localparam int PAGE_DEPTH = 1 << PAGE_AW;
  localparam int NSLOTS     = 3;
  localparam logic [7:0] SLOT_LO [NSLOTS] = '{8'h00, 8'h10, 8'h13};
  localparam logic [15:0] OVR_ADDR = 16'h5FF3;

  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_SCR  = 3'd1;
  localparam logic [2:0] SRC_PAGE = 3'd2;
  localparam logic [2:0] SRC_DFLT = 3'd3;
  localparam logic [2:0] SRC_SNAP = 3'd4;

  wire in_scr   = cpu_addr[15:12] == 4'h5;
  wire in_wram  = cpu_addr[15:13] == 3'b011;
  wire page_hit = ctrl_byte[7:5] == 3'b111;
  wire [1:0] page = ctrl_byte[1:0];

  wire [SCR_AW-1:0]  scr_a = cpu_addr[SCR_AW-1:0];
  wire [PAGE_AW-1:0] wr_a  = cpu_addr[PAGE_AW-1:0];

  logic [7:0] scr_mem  [SCR_DEPTH];
  logic [7:0] page_mem [NPAGES*PAGE_DEPTH];
  logic [7:0] dflt_mem [PAGE_DEPTH];

  wire scr_we = cpu_wr & in_scr;
  wire pg_we  = cpu_wr & in_wram & page_hit;
  wire df_we  = cpu_wr & in_wram & (~page_hit | (page == 2'd0));

  logic [7:0] scr_q, page_q, dflt_q;

  always_ff @(posedge clk) begin
    if (scr_we) scr_mem[scr_a] <= cpu_wdata;
    if (cpu_rd) scr_q <= scr_mem[scr_a];
  end

  always_ff @(posedge clk) begin
    if (pg_we) page_mem[{page, wr_a}] <= cpu_wdata;
    if (cpu_rd) page_q <= page_mem[{page, wr_a}];
  end

  always_ff @(posedge clk) begin
    if (df_we) dflt_mem[wr_a] <= cpu_wdata;
    if (cpu_rd) dflt_q <= dflt_mem[wr_a];
  end

  logic [7:0]        snap [NSLOTS];
  logic [NSLOTS-1:0] wr_arm, rd_arm, rd_take;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    wire wr_hit = cpu_wr && cpu_addr == {8'h50, SLOT_LO[i]};
    assign rd_take[i] = cpu_rd && !page_hit && rd_arm[i] &&
                        cpu_addr == {8'h60, SLOT_LO[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap[i]   <= '0;
        wr_arm[i] <= 1'b1;
        rd_arm[i] <= 1'b1;
      end else begin
        if (wr_hit && wr_arm[i]) begin
          snap[i]   <= cpu_wdata;
          wr_arm[i] <= 1'b0;
        end
        if (rd_take[i]) rd_arm[i] <= 1'b0;
      end
    end
  end

  logic [7:0] snap_sel;
  always_comb begin
    snap_sel = '0;
    for (int i = 0; i < NSLOTS; i++)
      if (rd_take[i]) snap_sel = snap[i];
  end

  logic [7:0] ovr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ovr_q <= '0;
    else if (cpu_wr && cpu_addr == OVR_ADDR) ovr_q <= cpu_wdata;
  end
  assign prg_force_zero = ovr_q == 8'd2;

  logic [2:0] src_d, src_q;
  logic [7:0] snap_q;
  always_comb begin
    src_d = SRC_NONE;
    if (cpu_rd) begin
      if (in_scr)          src_d = SRC_SCR;
      else if (in_wram) begin
        if (page_hit)      src_d = SRC_PAGE;
        else if (|rd_take) src_d = SRC_SNAP;
        else               src_d = SRC_DFLT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NONE;
      snap_q <= '0;
    end else begin
      src_q  <= src_d;
      snap_q <= snap_sel;
    end
  end

  assign rd_valid = src_q != SRC_NONE;
  always_comb begin
    case (src_q)
      SRC_SCR:  rd_data = scr_q;
      SRC_PAGE: rd_data = page_q;
      SRC_DFLT: rd_data = dflt_q;
      SRC_SNAP: rd_data = snap_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/xreg_wram_chk.sv
module xreg_wram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [7:0]  ctrl_byte,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic        prg_force_zero,
  input logic [2:0]  wr_arm,
  input logic [2:0]  rd_arm
);
  wire in_win = cpu_addr[15:12] inside {4'h5, 4'h6, 4'h7};

  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_win |=> rd_valid);

  a_r10_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !in_win |=> !rd_valid && rd_data == 8'd0);

  a_r8_force_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 16'h5FF3 |=> prg_force_zero == ($past(cpu_wdata) == 8'd2));

  a_r2_wr_arm_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arm & ~$past(wr_arm)) == 3'b000);

  a_r3_rd_arm_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_arm & ~$past(rd_arm)) == 3'b000);

  a_r7_page_keeps_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && ctrl_byte[7:5] == 3'b111 |=> rd_arm == $past(rd_arm));

  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |=> rd_arm == 3'b111 && wr_arm == 3'b111 && !prg_force_zero && !rd_valid);
endmodule

bind xreg_wram xreg_wram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ctrl_byte(ctrl_byte), .rd_data(rd_data),
  .rd_valid(rd_valid), .prg_force_zero(prg_force_zero),
  .wr_arm(wr_arm), .rd_arm(rd_arm)
);

// File: tb/xreg_wram_bench.sv
module xreg_wram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  ctrl_byte = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        prg_force_zero;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xreg_wram u_xreg_wram (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ctrl_byte(ctrl_byte),
    .rd_data(rd_data), .rd_valid(rd_valid), .prg_force_zero(prg_force_zero)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input string req,
                        input logic vexp, input logic [7:0] dexp);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check(req, {rd_valid, rd_data}, {vexp, dexp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset force", {8'd0, prg_force_zero}, 9'd0);
    check("R9 reset valid", {8'd0, rd_valid}, 9'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_scratch();
    bus_wr(16'h5020, 8'hA5);
    bus_wr(16'h5021, 8'h3C);
    bus_rd(16'h5020, "R1 scratch a", 1'b1, 8'hA5);
    bus_rd(16'h5021, "R1 scratch b", 1'b1, 8'h3C);
  endtask

  task automatic t_force();
    bus_wr(16'h5FF3, 8'h02);
    check("R8 force set", {8'd0, prg_force_zero}, 9'd1);
    bus_wr(16'h5FF3, 8'h03);
    check("R8 force clear", {8'd0, prg_force_zero}, 9'd0);
    bus_wr(16'h5FF3, 8'h02);
    check("R8 force set again", {8'd0, prg_force_zero}, 9'd1);
  endtask

  task automatic t_priority();
    bus_wr(16'h5000, 8'hAB);
    ctrl_byte = 8'hE0;
    bus_wr(16'h6000, 8'hC1);
    bus_rd(16'h6000, "R7 page over snapshot", 1'b1, 8'hC1);
    ctrl_byte = 8'h00;
    bus_rd(16'h6000, "R7 snapshot still armed", 1'b1, 8'hAB);
    bus_rd(16'h6000, "R5 page0 shadow in default", 1'b1, 8'hC1);
  endtask

  task automatic t_snapshot();
    ctrl_byte = 8'h00;
    bus_wr(16'h6010, 8'h88);
    bus_wr(16'h6013, 8'h99);
    bus_wr(16'h5010, 8'h22);
    bus_wr(16'h5013, 8'h33);
    bus_wr(16'h5010, 8'h55);
    bus_wr(16'h5013, 8'h66);
    bus_wr(16'h5000, 8'h44);
    bus_rd(16'h5010, "R2 live write reaches scratch", 1'b1, 8'h55);
    bus_rd(16'h6010, "R2 R3 first read 6010", 1'b1, 8'h22);
    bus_rd(16'h6010, "R3 second read 6010", 1'b1, 8'h88);
    bus_rd(16'h6013, "R2 R3 first read 6013", 1'b1, 8'h33);
    bus_rd(16'h6013, "R3 second read 6013", 1'b1, 8'h99);
    bus_rd(16'h6000, "R3 consumed 6000", 1'b1, 8'hC1);
  endtask

  task automatic t_pages();
    ctrl_byte = 8'h00;
    bus_wr(16'h6100, 8'h5A);
    ctrl_byte = 8'hE1; bus_wr(16'h6100, 8'hA1);
    ctrl_byte = 8'h00;
    bus_rd(16'h6100, "R5 page1 no shadow", 1'b1, 8'h5A);
    ctrl_byte = 8'hE2; bus_wr(16'h6100, 8'hA2);
    ctrl_byte = 8'hE3; bus_wr(16'h6100, 8'hA3);
    ctrl_byte = 8'hE0; bus_wr(16'h6100, 8'hA0);
    ctrl_byte = 8'hE1; bus_rd(16'h6100, "R4 page1", 1'b1, 8'hA1);
    ctrl_byte = 8'hE2; bus_rd(16'h6100, "R4 page2", 1'b1, 8'hA2);
    ctrl_byte = 8'hE3; bus_rd(16'h6100, "R4 page3", 1'b1, 8'hA3);
    ctrl_byte = 8'hE0; bus_rd(16'h6100, "R4 page0", 1'b1, 8'hA0);
    ctrl_byte = 8'hFD; bus_rd(16'h6100, "R4 ignored bits", 1'b1, 8'hA1);
    ctrl_byte = 8'h60; bus_rd(16'h6100, "R6 no match default", 1'b1, 8'hA0);
    ctrl_byte = 8'h00;
    bus_wr(16'h7F00, 8'h6E);
    bus_rd(16'h7F00, "R6 default bank", 1'b1, 8'h6E);
  endtask

  task automatic t_outside();
    bus_rd(16'h8000, "R10 outside high", 1'b0, 8'h00);
    bus_rd(16'h4FFF, "R10 outside low", 1'b0, 8'h00);
  endtask

  task automatic t_rearm();
    do_reset();
    ctrl_byte = 8'h00;
    bus_rd(16'h6013, "R9 cleared snapshot", 1'b1, 8'h00);
    bus_wr(16'h5000, 8'h12);
    bus_rd(16'h6000, "R9 rearmed snapshot", 1'b1, 8'h12);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_scratch();
        t_force();
        t_priority();
        t_snapshot();
        t_pages();
        t_outside();
        t_rearm();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule